// File: doc/BRIEF.md
# Command Register Writer with Scratch Mirroring

This block is the register-write stage of a command processor. It takes 32-bit command words over a valid/ready stream, decodes register-write packets, and presents each decoded write on a register-file write port. When a write lands on one of eight scratch registers and the matching bit of a mask register is set, the block also issues a 32-bit memory store of the same value. The store goes to a base address, held in another register, plus four times the scratch number.

The mask register and the base-address register pass through this block like any other write, so the block keeps private copies of both. Every decision uses the values written most recently, including writes made earlier in the same packet. Register writes and their stores leave in packet order. While a store waits for the memory side, the command input is held off.

Top module: `cmd_regwr`

## Requirements
- R1: After reset `cmd_ready` is 1, `rf_we` is 0 and `mem_valid` is 0. The mask and base copies are zero, so no scratch write is mirrored until the mask register (index 0x1DC) is written.
- R2: A header with bits 31:30 = 00 starts a linear packet. Bits 29:16 hold the payload count minus one, bit 15 is the write-one flag and bits 14:0 give the first register index. Payload words are written to index, index+1, and so on. Each write appears on the register-file port (`rf_we`, `rf_idx`, `rf_wdata`) in the cycle after its word is accepted.
- R3: With bit 15 set, every payload word of the linear packet is written to the first register index.
- R4: A header with bits 31:30 = 01 starts a paired packet. Register A is in bits 10:0 and register B is in bits 21:11. The next accepted word is written to A, and the word after it is written to B.
- R5: A header with bits 31:30 = 10 or 11 is consumed as a single word and causes no register write and no store.
- R6: Scratch register n (0 to 7) has index 0x578+n. A write to it raises `mem_valid` in the same cycle as its register write when bit n of the mask (low 8 bits of register 0x1DC) is set.
- R7: When the mask bit is clear, or when the target index is outside 0x578 to 0x57F, the write produces no store.
- R8: The store address is the value of register 0x1DD plus 4*n, modulo 2^32.
- R9: The store is big-endian. `mem_wdata[7:0]`, the lowest-address byte lane, carries bits 31:24 of the value, and `mem_wdata[31:24]` carries bits 7:0.
- R10: Each mirroring decision uses the mask and base values from the most recent earlier write to them, including writes made earlier in the same packet.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_wdata` stay unchanged and `cmd_ready` is 0. Otherwise `cmd_ready` is 1.
- R12: Exactly one register write is produced per accepted payload word, in the order the words were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when high together with valid |
| cmd_word | input | 32 | Command word |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 15 | Register index being written |
| rf_wdata | output | 32 | Register write value |
| mem_valid | output | 1 | Store request pending |
| mem_ready | input | 1 | Memory side accepts the store |
| mem_addr | output | 32 | Store byte address |
| mem_wdata | output | 32 | Store data in byte-lane order |

## Verification
The stimulus mixes several patterns. Linear packets that straddle the scratch window show whether the range test is off by one at either end. Write-one bursts onto a single scratch register separate per-word mirroring from per-packet mirroring. Paired packets that write the mask or base and then a scratch register show whether a same-packet update takes effect. A base near the top of the address space checks that the offset wraps. Each pattern is run with the memory side always ready and again with pseudo-random stalls, which separates correct hold-off and ordering from designs that drop or overwrite a pending store.

// File: rtl/cmd_regwr.sv
module cmd_regwr #(
  parameter int IDX_W   = 15,
  parameter int CNT_W   = 14,
  parameter int ADDR_W  = 32,
  parameter int SCR_NUM = 8,
  parameter logic [IDX_W-1:0] SCR_BASE  = 15'h578,
  parameter logic [IDX_W-1:0] MASK_IDX  = 15'h1DC,
  parameter logic [IDX_W-1:0] BASEA_IDX = 15'h1DD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_word,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [31:0]       rf_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int DW     = 32;
  localparam int PAIR_W = 11;
  localparam int SEL_W  = (SCR_NUM > 1) ? $clog2(SCR_NUM) : 1;

  typedef enum logic [1:0] {S_HDR, S_LIN, S_PA, S_PB} st_t;

  st_t               st;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [CNT_W-1:0]  left;
  logic              one;
  logic [SCR_NUM-1:0] mask_q;
  logic [ADDR_W-1:0] base_q;

  wire              take    = cmd_valid & cmd_ready;
  wire              data_ph = (st != S_HDR);
  wire              wr      = take & data_ph;
  wire [IDX_W-1:0]  tgt     = (st == S_PB) ? idx_b : idx_a;
  wire [IDX_W-1:0]  off     = tgt - SCR_BASE;
  wire              in_scr  = (tgt >= SCR_BASE) && (off < IDX_W'(SCR_NUM));
  wire [SEL_W-1:0]  sel     = off[SEL_W-1:0];
  wire              mirror  = wr & in_scr & mask_q[sel];

  logic [DW-1:0] swapped;
  for (genvar b = 0; b < DW / 8; b++) begin : g_swap
    assign swapped[8*b +: 8] = cmd_word[DW-1-8*b -: 8];
  end

  assign cmd_ready = !mem_valid || mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we    <= 1'b0;
      rf_idx   <= '0;
      rf_wdata <= '0;
    end else begin
      rf_we <= wr;
      if (wr) begin
        rf_idx   <= tgt;
        rf_wdata <= cmd_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mirror) begin
      mem_valid <= 1'b1;
      mem_addr  <= base_q + ADDR_W'({sel, 2'b00});
      mem_wdata <= swapped;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else if (wr) begin
      if (tgt == MASK_IDX)  mask_q <= cmd_word[SCR_NUM-1:0];
      if (tgt == BASEA_IDX) base_q <= cmd_word[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_HDR;
      idx_a <= '0;
      idx_b <= '0;
      left  <= '0;
      one   <= 1'b0;
    end else if (take) begin
      case (st)
        S_HDR: begin
          case (cmd_word[31:30])
            2'b00: begin
              idx_a <= cmd_word[IDX_W-1:0];
              one   <= cmd_word[15];
              left  <= cmd_word[16 +: CNT_W];
              st    <= S_LIN;
            end
            2'b01: begin
              idx_a <= IDX_W'(cmd_word[0 +: PAIR_W]);
              idx_b <= IDX_W'(cmd_word[PAIR_W +: PAIR_W]);
              st    <= S_PA;
            end
            default: st <= S_HDR;
          endcase
        end
        S_LIN: begin
          if (left == '0) begin
            st <= S_HDR;
          end else begin
            left <= left - CNT_W'(1);
            if (!one) idx_a <= idx_a + IDX_W'(1);
          end
        end
        S_PA:    st <= S_PB;
        default: st <= S_HDR;
      endcase
    end
  end
endmodule

module cmd_regwr_chk #(
  parameter int IDX_W = 15,
  parameter logic [IDX_W-1:0] SCR_BASE = 15'h578
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rf_we,
  input logic [IDX_W-1:0] rf_idx,
  input logic [31:0]      rf_wdata,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata
);
  logic stalled_q;
  always_ff @(posedge clk) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= mem_valid & ~mem_ready;
  end
  wire new_req = mem_valid & ~stalled_q;
  wire idx_scr = (rf_idx >= SCR_BASE) && (rf_idx < SCR_BASE + IDX_W'(8));
  wire [31:0] rf_swap = {rf_wdata[7:0], rf_wdata[15:8], rf_wdata[23:16], rf_wdata[31:24]};

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rf_we && !mem_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !cmd_ready);
  p_req_scratch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |-> rf_we && idx_scr);
  p_endian_r9: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |-> mem_wdata == rf_swap);
  p_write_per_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(cmd_valid && cmd_ready));
endmodule

bind cmd_regwr cmd_regwr_chk u_chk (.*);

// File: tb/cmd_regwr_tb.sv
`timescale 1ns/1ps
module cmd_regwr_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, rf_we, mem_valid, mem_ready;
  logic [31:0] cmd_word, rf_wdata, mem_addr, mem_wdata;
  logic [14:0] rf_idx;

  cmd_regwr u_dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int compared = 0, mismatched = 0;
  string tag = "R1";

  int          m_st = 0, m_left = 0;
  bit          m_one = 0;
  logic [14:0] m_a = 0, m_b = 0;
  logic [31:0] m_mask = 0, m_base = 0;
  bit          e_v = 0;
  logic [14:0] e_idx = 0;
  logic [31:0] e_dat = 0;
  logic [31:0] q_addr[$], q_data[$];
  logic [31:0] stim[$];
  bit          bp = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] t0(int base, int cnt, bit one_f);
    return {2'b00, 14'(cnt - 1), one_f, 15'(base)};
  endfunction
  function automatic logic [31:0] t1(int a, int b);
    return {2'b01, 8'h00, 11'(b), 11'(a)};
  endfunction

  task automatic model(logic [31:0] w);
    logic [14:0] t;
    e_v = 0;
    if (m_st == 0) begin
      if (w[31:30] == 2'b00) begin
        m_a = w[14:0]; m_one = w[15]; m_left = int'(w[29:16]); m_st = 1;
      end else if (w[31:30] == 2'b01) begin
        m_a = {4'b0, w[10:0]}; m_b = {4'b0, w[21:11]}; m_st = 2;
      end
    end else begin
      t = (m_st == 3) ? m_b : m_a;
      e_v = 1; e_idx = t; e_dat = w;
      if (t >= 15'h578 && t <= 15'h57F && m_mask[t - 15'h578]) begin
        q_addr.push_back(m_base + 32'(4 * int'(t - 15'h578)));
        q_data.push_back({w[7:0], w[15:8], w[23:16], w[31:24]});
      end
      if (t == 15'h1DC) m_mask = w;
      if (t == 15'h1DD) m_base = w;
      if (m_st == 1) begin
        if (m_left == 0) m_st = 0;
        else begin m_left--; if (!m_one) m_a = m_a + 1; end
      end else if (m_st == 2) m_st = 3;
      else m_st = 0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(rf_we == e_v, {tag, " R12 rf_we"}, 64'(rf_we), 64'(e_v));
    if (e_v) begin
      chk(rf_idx == e_idx, {tag, " R2 rf_idx"}, 64'(rf_idx), 64'(e_idx));
      chk(rf_wdata == e_dat, {tag, " R2 rf_wdata"}, 64'(rf_wdata), 64'(e_dat));
    end
    chk(mem_valid == (q_addr.size() > 0), {tag, " R6/R7 mem_valid"}, 64'(mem_valid), 64'(q_addr.size() > 0));
    if (q_addr.size() > 0) begin
      chk(mem_addr == q_addr[0], {tag, " R8 mem_addr"}, 64'(mem_addr), 64'(q_addr[0]));
      chk(mem_wdata == q_data[0], {tag, " R9 mem_wdata"}, 64'(mem_wdata), 64'(q_data[0]));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = bp ? lfsr[0] : 1'b1;
    cmd_valid = (stim.size() > 0) && (lfsr[3:2] != 2'b00);
    cmd_word  = (stim.size() > 0) ? stim[0] : 32'h0;
    #1;
    chk(cmd_ready == (q_addr.size() == 0 || mem_ready), {tag, " R11 cmd_ready"},
        64'(cmd_ready), 64'(q_addr.size() == 0 || mem_ready));
    if (q_addr.size() > 0 && mem_ready) begin
      void'(q_addr.pop_front()); void'(q_data.pop_front());
    end
    if (cmd_valid && cmd_ready) model(stim.pop_front());
    else e_v = 0;
  endtask

  task automatic run();
    while (stim.size() > 0 || q_addr.size() > 0) step();
    repeat (3) step();
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(4ns * 150000);
    mismatched++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_up();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_word = 0; mem_ready = 1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1, "R1 reset cmd_ready", 64'(cmd_ready), 1);
    chk(rf_we == 0, "R1 reset rf_we", 64'(rf_we), 0);
    chk(mem_valid == 0, "R1 reset mem_valid", 64'(mem_valid), 0);
    rst_n = 1;

    for (int pass = 0; pass < 2; pass++) begin
      bp = (pass == 1);
      tag = "R1";  stim.push_back(t0(15'h57A, 1, 0)); stim.push_back(32'hDEAD0001); run();
      tag = "R10"; stim.push_back(t0(15'h1DC, 2, 0)); stim.push_back(32'h10); stim.push_back(32'h40001000); run();
      tag = "R6";  stim.push_back(t0(15'h57B, 2, 0)); stim.push_back(32'h11111111); stim.push_back(32'h824CE2B8); run();
      tag = "R3";  stim.push_back(t0(15'h1DC, 1, 0)); stim.push_back(32'hFF);
      stim.push_back(t0(15'h57C, 3, 1));
      for (int i = 0; i < 3; i++) stim.push_back(32'hA0B0C000 + i);
      run();
      tag = "R7";  stim.push_back(t0(15'h577, 3, 0));
      for (int i = 0; i < 3; i++) stim.push_back(32'h01020300 + i);
      stim.push_back(t0(15'h57E, 3, 0));
      for (int i = 0; i < 3; i++) stim.push_back(32'h0E0F1000 + i);
      run();
      tag = "R4";  stim.push_back(t1(15'h100, 15'h57F)); stim.push_back(32'h12345678); stim.push_back(32'h9ABCDEF0); run();
      tag = "R5";  stim.push_back(32'h80001234); stim.push_back(32'hC0000578);
      stim.push_back(t0(15'h200, 1, 0)); stim.push_back(32'h55AA55AA); run();
      tag = "R8";  stim.push_back(t1(15'h1DD, 15'h57F)); stim.push_back(32'hFFFFFFF8); stim.push_back(32'hCAFEBABE); run();
      tag = "R10"; stim.push_back(t1(15'h1DC, 15'h578)); stim.push_back(32'h0); stim.push_back(32'h77777777);
      stim.push_back(t1(15'h1DC, 15'h578)); stim.push_back(32'h1); stim.push_back(32'h66666666); run();
      tag = "R11"; stim.push_back(t0(15'h1DD, 1, 0)); stim.push_back(32'h00002000);
      stim.push_back(t0(15'h1DC, 1, 0)); stim.push_back(32'hFF);
      stim.push_back(t0(15'h578, 8, 0));
      for (int i = 0; i < 8; i++) stim.push_back(32'h3000 + i);
      run();
      tag = "R2";  stim.push_back(t0(15'h300, 20, 0));
      for (int i = 0; i < 20; i++) stim.push_back(32'h4400 + i);
      run();
      tag = "R12"; stim.push_back(t0(15'h57A, 2, 0)); stim.push_back(32'hBEEF0001); stim.push_back(32'hBEEF0002);
      stim.push_back(t1(15'h57D, 15'h579)); stim.push_back(32'hBEEF0003); stim.push_back(32'hBEEF0004); run();
    end
    chk(q_addr.size() == 0, "R12 stores drained", 64'(q_addr.size()), 0);
    finish_up();
  end
endmodule